// File: doc/BRIEF.md
# Serial Port Register File and Interrupt Arbiter

This block is the register file that a host sees on a PC-style asynchronous serial port. The host reaches eight byte-wide registers through a 3-bit offset and separate read and write strobes. The block keeps the line, modem, FIFO and interrupt-enable settings and the 16-bit baud divisor. It hands these settings to the serial datapath on dedicated outputs. It also turns datapath events into a single prioritised interrupt.

The datapath reports three kinds of event as one-cycle pulses: a received byte, the transmit holding register becoming empty, and a line error. Each event sets a sticky condition. A condition counts toward the interrupt only when its enable bit is set. The interrupt identification register names the most urgent enabled condition, and a registered request line tells the host that something is pending. Specific register reads and writes acknowledge each condition.

The offsets are:

| Offset | Read | Write |
|---|---|---|
| 0 | receive data | transmit data |
| 1 | interrupt enable | interrupt enable |
| 2 | interrupt identification | FIFO control |
| 3 | line control | line control |
| 4 | modem control | modem control |
| 5 | line status | — |
| 6 | always 0 | — |
| 7 | scratch | scratch |

Top module: `uart_regint`

## Requirements
- R1: After reset, the baud divisor is 96, `fifo_ctrl` is 0x06, `fifo_on` is 0, `rx_trig_depth` is 1, the enable register reads 0x00, offset 2 reads 0x01 and `irq` is 0.
- R2: While line control bit 7 is 1, offsets 0 and 1 read and write the low and high divisor bytes, and a write to offset 1 leaves the interrupt enable register unchanged. While bit 7 is 0, the same offsets reach data and interrupt enable.
- R3: A write to interrupt enable keeps only bits 3:0. A write to modem control keeps only bits 4:0. Scratch keeps all 8 bits. Offset 6 reads 0x00.
- R4: A FIFO control write stores the value ANDed with 0xF9 on `fifo_ctrl`, and `fifo_on` takes bit 0. With bit 0 set, bits 7:6 = 0, 1, 2, 3 give `rx_trig_depth` = 1, 4, 8, 14.
- R5: A FIFO control write with bit 0 clear pulses both `rx_fifo_flush` and `tx_fifo_flush` for one cycle and forces `rx_trig_depth` to 1.
- R6: A FIFO control write with bits 0 and 1 set pulses `rx_fifo_flush` only, and clears the received-data condition.
- R7: Offset 2 reads {fifo_on, fifo_on, 2'b00, code}. The code is 0x6 for a line error enabled by enable bit 2. Otherwise it is 0x4 for received data enabled by enable bit 0. Otherwise it is 0x2 for transmit empty enabled by enable bit 1.
- R8: With no enabled condition, offset 2 reads 0x01 (0xC1 while the FIFO is on) and `irq` is 0. Conditions that are masked off still show in line status.
- R9: With the FIFO off, reading received data at offset 0 clears the received-data condition. With the FIFO on, the same read leaves that condition set.
- R10: Reading offset 2 while it shows code 0x2 clears the transmit-empty condition. A data write to offset 0 also clears it, and pulses `tx_load` with the byte on `tx_byte`.
- R11: Line status reads bit 0 = received-data condition, bit 1 = line-error condition, bit 5 = transmit-empty condition, other bits 0. Reading it clears the line-error condition.
- R12: `irq` is a register. It reflects the enabled conditions one clock after they change: an event sampled at edge k raises `irq` after edge k+1.
- R13: A line control write that changes bits 3:0 pulses `frame_update` for one cycle. A write that changes only bits 7:4 does not pulse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered one cycle after `reg_rd` |
| rx_push | input | 1 | Received-byte event from the datapath |
| rx_byte | input | 8 | Received byte captured on `rx_push` |
| tx_ready_evt | input | 1 | Transmit holding register became empty |
| line_err_evt | input | 1 | Line error event |
| irq | output | 1 | Registered interrupt request |
| baud_div | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control value |
| modem_ctrl | output | 8 | Modem control value |
| fifo_ctrl | output | 8 | Stored FIFO control value |
| fifo_on | output | 1 | FIFOs enabled |
| rx_trig_depth | output | 4 | Receive trigger depth in bytes |
| rx_fifo_flush | output | 1 | One-cycle receive FIFO clear pulse |
| tx_fifo_flush | output | 1 | One-cycle transmit FIFO clear pulse |
| frame_update | output | 1 | One-cycle pulse: frame format changed |
| tx_load | output | 1 | One-cycle pulse: new transmit byte |
| tx_byte | output | 8 | Byte written for transmission |

## Verification
The bench raises all three conditions at once and then retires them one at a time. It checks that the identification code steps through 6, 4, 2 and then 0x01. A design with the wrong priority would report data or transmit-empty while a line error is still open. A design that did not acknowledge on read would stay stuck on one code. The bench writes the enable register while the divisor latch is open and later reads the enable register back. A design that failed to remap offset 1 would show 0x02 there instead of 0x00. The bench also counts the edges between an event and the rise of `irq`, to catch a request that is combinational or two cycles late. It then reads received data with the FIFO on, where a design that cleared the condition anyway would drop the code from 4 to 1.

// File: rtl/uart_ri_pkg.sv
package uart_ri_pkg;
  localparam int DW    = 8;
  localparam int DIV_W = 2 * DW;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  typedef enum logic [3:0] {
    INT_NONE = 4'h1,
    INT_TX   = 4'h2,
    INT_RX   = 4'h4,
    INT_LINE = 4'h6
  } int_id_e;

  function automatic logic [3:0] depth_of(input logic [1:0] code);
    case (code)
      2'd0:    depth_of = 4'd1;
      2'd1:    depth_of = 4'd4;
      2'd2:    depth_of = 4'd8;
      default: depth_of = 4'd14;
    endcase
  endfunction
endpackage

// File: rtl/uart_ri_regs.sv
module uart_ri_regs
  import uart_ri_pkg::*;
#(
  parameter logic [15:0] DIV_RESET = 16'd96,
  parameter logic [7:0]  FCR_RESET = 8'h06
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    lcr,
  output logic [3:0]       ier,
  output logic [4:0]       mcr,
  output logic [DW-1:0]    scr,
  output logic [DIV_W-1:0] div_q,
  output logic [DW-1:0]    fcr,
  output logic             fifo_en,
  output logic [3:0]       rx_depth,
  output logic             rx_clr,
  output logic             tx_clr,
  output logic             frame_recalc,
  output logic             thr_load,
  output logic [DW-1:0]    thr_byte
);
  logic dlab;
  assign dlab = lcr[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr          <= '0;
      ier          <= '0;
      mcr          <= '0;
      scr          <= '0;
      div_q        <= DIV_RESET;
      fcr          <= FCR_RESET;
      fifo_en      <= FCR_RESET[0];
      rx_depth     <= FCR_RESET[0] ? depth_of(FCR_RESET[7:6]) : 4'd1;
      rx_clr       <= 1'b0;
      tx_clr       <= 1'b0;
      frame_recalc <= 1'b0;
      thr_load     <= 1'b0;
      thr_byte     <= '0;
    end else begin
      rx_clr       <= 1'b0;
      tx_clr       <= 1'b0;
      frame_recalc <= 1'b0;
      thr_load     <= 1'b0;
      if (wr_en) begin
        case (addr)
          OFS_DATA: begin
            if (dlab) div_q[DW-1:0] <= wr_data;
            else begin
              thr_load <= 1'b1;
              thr_byte <= wr_data;
            end
          end
          OFS_IER: begin
            if (dlab) div_q[DIV_W-1:DW] <= wr_data;
            else      ier <= wr_data[3:0];
          end
          OFS_IIR: begin
            fcr     <= wr_data & 8'hF9;
            fifo_en <= wr_data[0];
            if (!wr_data[0]) begin
              rx_clr   <= 1'b1;
              tx_clr   <= 1'b1;
              rx_depth <= 4'd1;
            end else begin
              rx_clr   <= wr_data[1];
              rx_depth <= depth_of(wr_data[7:6]);
            end
          end
          OFS_LCR: begin
            lcr          <= wr_data;
            frame_recalc <= (wr_data[3:0] != lcr[3:0]);
          end
          OFS_MCR: mcr <= wr_data[4:0];
          OFS_SCR: scr <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // R2: divisor-mode writes to offset 1 must not touch the enable register
  a_r2_dlab_keeps_ier: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_IER && dlab) |=> $stable(ier));

  // R5: FIFOs off always means a trigger depth of one byte
  a_r5_off_depth_one: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |-> (rx_depth == 4'd1));

  // R13: a frame update pulse only follows a line control write
  a_r13_update_from_lcr: assert property (@(posedge clk) disable iff (rst)
    frame_recalc |-> $past(wr_en && addr == OFS_LCR));

  // R5: flushing the transmit FIFO always comes with a receive flush
  a_r5_tx_flush_pair: assert property (@(posedge clk) disable iff (rst)
    tx_clr |-> rx_clr);
endmodule

// File: rtl/uart_ri_intc.sv
module uart_ri_intc
  import uart_ri_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    ier,
  input  logic          fifo_en,
  input  logic          rx_evt,
  input  logic          tx_evt,
  input  logic          ls_evt,
  input  logic          rbr_rd,
  input  logic          lsr_rd,
  input  logic          iir_rd,
  input  logic          thr_wr,
  input  logic          rx_clr,
  output logic [DW-1:0] iir_val,
  output logic [DW-1:0] lsr_val,
  output logic          irq
);
  logic rx_cond, tx_cond, ls_cond;
  logic ls_sel, rx_sel, tx_sel, any_pending;
  int_id_e cur_id;

  always_comb begin
    ls_sel      = ier[2] & ls_cond;
    rx_sel      = ier[0] & rx_cond & ~ls_sel;
    tx_sel      = ier[1] & tx_cond & ~ls_sel & ~rx_sel;
    any_pending = ls_sel | rx_sel | tx_sel;
    if (ls_sel)      cur_id = INT_LINE;
    else if (rx_sel) cur_id = INT_RX;
    else if (tx_sel) cur_id = INT_TX;
    else             cur_id = INT_NONE;
  end

  assign iir_val = {fifo_en, fifo_en, 2'b00, cur_id};
  assign lsr_val = {2'b00, tx_cond, 3'b000, ls_cond, rx_cond};

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_cond <= 1'b0;
      tx_cond <= 1'b0;
      ls_cond <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (rx_evt)                    rx_cond <= 1'b1;
      else if (rx_clr)               rx_cond <= 1'b0;
      else if (rbr_rd && !fifo_en)   rx_cond <= 1'b0;

      if (ls_evt)                    ls_cond <= 1'b1;
      else if (lsr_rd)               ls_cond <= 1'b0;

      if (tx_evt)                    tx_cond <= 1'b1;
      else if (thr_wr)               tx_cond <= 1'b0;
      else if (iir_rd && cur_id == INT_TX) tx_cond <= 1'b0;

      irq <= any_pending;
    end
  end

  // R7: at most one source selected at a time
  a_r7_single_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ls_sel, rx_sel, tx_sel}));

  // R12: the request rises only after a pending source was seen
  a_r12_irq_rise_lag: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(any_pending));

  // R9: with FIFOs on, reading data keeps the receive condition
  a_r9_fifo_read_keeps: assert property (@(posedge clk) disable iff (rst)
    (rbr_rd && fifo_en && rx_cond && !rx_clr) |=> rx_cond);

  // R11: reading line status retires a line error unless a new one arrives
  a_r11_lsr_read_clears: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !ls_evt) |=> !ls_cond);
endmodule

// File: rtl/uart_regint.sv
module uart_regint
  import uart_ri_pkg::*;
#(
  parameter logic [15:0] DIV_RESET = 16'd96,
  parameter logic [7:0]  FCR_RESET = 8'h06
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        tx_ready_evt,
  input  logic        line_err_evt,
  output logic        irq,
  output logic [15:0] baud_div,
  output logic [7:0]  line_ctrl,
  output logic [7:0]  modem_ctrl,
  output logic [7:0]  fifo_ctrl,
  output logic        fifo_on,
  output logic [3:0]  rx_trig_depth,
  output logic        rx_fifo_flush,
  output logic        tx_fifo_flush,
  output logic        frame_update,
  output logic        tx_load,
  output logic [7:0]  tx_byte
);
  logic [DW-1:0] lcr, scr, fcr, rbr, iir_val, lsr_val, thr_byte, rd_mux;
  logic [3:0]    ier;
  logic [4:0]    mcr;
  logic [DIV_W-1:0] div_q;
  logic fifo_en, rx_clr, tx_clr, frame_recalc, thr_load;
  logic dlab, rbr_rd, lsr_rd, iir_rd;

  uart_ri_regs #(.DIV_RESET(DIV_RESET), .FCR_RESET(FCR_RESET)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wr_data(reg_wdata),
    .lcr(lcr), .ier(ier), .mcr(mcr), .scr(scr), .div_q(div_q), .fcr(fcr),
    .fifo_en(fifo_en), .rx_depth(rx_trig_depth), .rx_clr(rx_clr), .tx_clr(tx_clr),
    .frame_recalc(frame_recalc), .thr_load(thr_load), .thr_byte(thr_byte)
  );

  assign dlab   = lcr[DW-1];
  assign rbr_rd = reg_rd && reg_addr == OFS_DATA && !dlab;
  assign lsr_rd = reg_rd && reg_addr == OFS_LSR;
  assign iir_rd = reg_rd && reg_addr == OFS_IIR;

  uart_ri_intc u_intc (
    .clk(clk), .rst(rst), .ier(ier), .fifo_en(fifo_en),
    .rx_evt(rx_push), .tx_evt(tx_ready_evt), .ls_evt(line_err_evt),
    .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .iir_rd(iir_rd),
    .thr_wr(reg_wr && reg_addr == OFS_DATA && !dlab), .rx_clr(rx_clr),
    .iir_val(iir_val), .lsr_val(lsr_val), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      OFS_DATA: rd_mux = dlab ? div_q[DW-1:0] : rbr;
      OFS_IER:  rd_mux = dlab ? div_q[DIV_W-1:DW] : {4'b0000, ier};
      OFS_IIR:  rd_mux = iir_val;
      OFS_LCR:  rd_mux = lcr;
      OFS_MCR:  rd_mux = {3'b000, mcr};
      OFS_LSR:  rd_mux = lsr_val;
      OFS_MSR:  rd_mux = '0;
      default:  rd_mux = scr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbr       <= '0;
      reg_rdata <= '0;
    end else begin
      if (rx_push) rbr <= rx_byte;
      if (reg_rd)  reg_rdata <= rd_mux;
    end
  end

  assign baud_div      = div_q;
  assign line_ctrl     = lcr;
  assign modem_ctrl    = {3'b000, mcr};
  assign fifo_ctrl     = fcr;
  assign fifo_on       = fifo_en;
  assign rx_fifo_flush = rx_clr;
  assign tx_fifo_flush = tx_clr;
  assign frame_update  = frame_recalc;
  assign tx_load       = thr_load;
  assign tx_byte       = thr_byte;

  // R8: request low whenever identification shows nothing pending for two cycles
  a_r8_idle_no_irq: assert property (@(posedge clk) disable iff (rst)
    ($past(iir_val[0]) && iir_val[0]) |-> !irq);
endmodule

// File: tb/sim_uart_regint.sv
module sim_uart_regint;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic rx_push = 1'b0, tx_ready_evt = 1'b0, line_err_evt = 1'b0;
  logic [7:0] rx_byte = '0;
  logic irq, fifo_on, rx_fifo_flush, tx_fifo_flush, frame_update, tx_load;
  logic [15:0] baud_div;
  logic [7:0] line_ctrl, modem_ctrl, fifo_ctrl, tx_byte;
  logic [3:0] rx_trig_depth;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  uart_regint u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_push(rx_push), .rx_byte(rx_byte),
    .tx_ready_evt(tx_ready_evt), .line_err_evt(line_err_evt), .irq(irq),
    .baud_div(baud_div), .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl),
    .fifo_ctrl(fifo_ctrl), .fifo_on(fifo_on), .rx_trig_depth(rx_trig_depth),
    .rx_fifo_flush(rx_fifo_flush), .tx_fifo_flush(tx_fifo_flush),
    .frame_update(frame_update), .tx_load(tx_load), .tx_byte(tx_byte)
  );

  // vector: {write, offset[2:0], data[7:0], expected[7:0], req[3:0]}
  localparam int NV = 20;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 3'd1, 8'h00, 8'h00, 4'd1},  // R1 enable reads zero
    {1'b1, 3'd3, 8'h80, 8'h00, 4'd2},  // R2 open divisor latch
    {1'b0, 3'd0, 8'h00, 8'h60, 4'd1},  // R1 divisor low = 96
    {1'b0, 3'd1, 8'h00, 8'h00, 4'd1},  // R1 divisor high = 0
    {1'b1, 3'd0, 8'h34, 8'h00, 4'd2},
    {1'b1, 3'd1, 8'h12, 8'h00, 4'd2},
    {1'b0, 3'd0, 8'h00, 8'h34, 4'd2},  // R2
    {1'b0, 3'd1, 8'h00, 8'h12, 4'd2},  // R2
    {1'b1, 3'd3, 8'h03, 8'h00, 4'd2},
    {1'b0, 3'd3, 8'h00, 8'h03, 4'd2},
    {1'b0, 3'd1, 8'h00, 8'h00, 4'd2},  // R2 enable untouched by divisor write
    {1'b1, 3'd1, 8'hFF, 8'h00, 4'd3},
    {1'b0, 3'd1, 8'h00, 8'h0F, 4'd3},  // R3
    {1'b1, 3'd1, 8'h00, 8'h00, 4'd3},
    {1'b1, 3'd4, 8'hFF, 8'h00, 4'd3},
    {1'b0, 3'd4, 8'h00, 8'h1F, 4'd3},  // R3
    {1'b1, 3'd7, 8'hA5, 8'h00, 4'd3},
    {1'b0, 3'd7, 8'h00, 8'hA5, 4'd3},  // R3
    {1'b0, 3'd6, 8'h00, 8'h00, 4'd3},  // R3
    {1'b0, 3'd2, 8'h00, 8'h01, 4'd8}   // R8
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, {8'h00, reg_rdata}, {8'h00, exp});
  endtask

  task automatic pulse(input logic rx, input logic tx, input logic ls, input logic [7:0] b);
    @(negedge clk);
    rx_push = rx; tx_ready_evt = tx; line_err_evt = ls; rx_byte = b;
    @(negedge clk);
    rx_push = 1'b0; tx_ready_evt = 1'b0; line_err_evt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 divisor", baud_div, 16'd96);
    chk("R1 fifo_ctrl", {8'h00, fifo_ctrl}, 16'h0006);
    chk("R1 fifo_on", {15'd0, fifo_on}, 16'd0);
    chk("R1 depth", {12'd0, rx_trig_depth}, 16'd1);
    chk("R1 irq", {15'd0, irq}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][23]) wr(VEC[i][22:20], VEC[i][19:12]);
      else rd_chk(VEC[i][22:20], VEC[i][11:4], $sformatf("R%0d vec %0d", VEC[i][3:0], i));
    end
    chk("R2 divisor out", baud_div, 16'h1234);

    // R13 frame update pulse (line control currently 0x03)
    wr(3'd3, 8'h83);
    chk("R13 upper bits only", {15'd0, frame_update}, 16'd0);
    wr(3'd3, 8'h07);
    chk("R13 low bits change", {15'd0, frame_update}, 16'd1);
    wr(3'd3, 8'h07);
    chk("R13 same value", {15'd0, frame_update}, 16'd0);

    // R12 and R7: priority walk
    wr(3'd1, 8'h07);
    pulse(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R12 irq not yet", {15'd0, irq}, 16'd0);
    @(negedge clk);
    chk("R12 irq one cycle later", {15'd0, irq}, 16'd1);
    pulse(1'b1, 1'b0, 1'b1, 8'h5A);
    rd_chk(3'd2, 8'h06, "R7 line first");
    rd_chk(3'd5, 8'h23, "R11 status bits");
    rd_chk(3'd2, 8'h04, "R7 data second");
    rd_chk(3'd0, 8'h5A, "R9 data byte");
    rd_chk(3'd2, 8'h02, "R7 tx third");
    rd_chk(3'd2, 8'h01, "R10 tx cleared by id read");
    @(negedge clk);
    chk("R8 irq low idle", {15'd0, irq}, 16'd0);

    // R8 masked conditions, R10 transmit write clears
    wr(3'd1, 8'h00);
    pulse(1'b0, 1'b1, 1'b0, 8'h00);
    @(negedge clk);
    rd_chk(3'd2, 8'h01, "R8 masked id");
    chk("R8 masked irq", {15'd0, irq}, 16'd0);
    rd_chk(3'd5, 8'h20, "R8 masked still in status");
    wr(3'd0, 8'hC3);
    chk("R10 tx_load", {15'd0, tx_load}, 16'd1);
    chk("R10 tx_byte", {8'h00, tx_byte}, 16'h00C3);
    rd_chk(3'd5, 8'h00, "R10 write clears tx");

    // R4 / R6 / R9 FIFO mode
    wr(3'd2, 8'h01);
    chk("R4 fifo_on", {15'd0, fifo_on}, 16'd1);
    chk("R4 depth code0", {12'd0, rx_trig_depth}, 16'd1);
    wr(3'd1, 8'h01);
    pulse(1'b1, 1'b0, 1'b0, 8'h77);
    rd_chk(3'd2, 8'hC4, "R7 fifo id");
    rd_chk(3'd0, 8'h77, "R9 fifo data");
    rd_chk(3'd2, 8'hC4, "R9 fifo read keeps condition");
    wr(3'd2, 8'h03);
    chk("R6 rx flush", {15'd0, rx_fifo_flush}, 16'd1);
    chk("R6 no tx flush", {15'd0, tx_fifo_flush}, 16'd0);
    chk("R4 masked store", {8'h00, fifo_ctrl}, 16'h0001);
    rd_chk(3'd2, 8'hC1, "R6 flush clears data cond");
    wr(3'd2, 8'hC7);
    chk("R4 store C7", {8'h00, fifo_ctrl}, 16'h00C1);
    chk("R4 depth 14", {12'd0, rx_trig_depth}, 16'd14);
    wr(3'd2, 8'h41);
    chk("R4 depth 4", {12'd0, rx_trig_depth}, 16'd4);
    chk("R6 no flush without bit1", {15'd0, rx_fifo_flush}, 16'd0);
    wr(3'd2, 8'h81);
    chk("R4 depth 8", {12'd0, rx_trig_depth}, 16'd8);

    // R5 disable
    wr(3'd2, 8'h80);
    chk("R5 store", {8'h00, fifo_ctrl}, 16'h0080);
    chk("R5 fifo off", {15'd0, fifo_on}, 16'd0);
    chk("R5 depth 1", {12'd0, rx_trig_depth}, 16'd1);
    chk("R5 rx flush", {15'd0, rx_fifo_flush}, 16'd1);
    chk("R5 tx flush", {15'd0, tx_fifo_flush}, 16'd1);
    rd_chk(3'd2, 8'h01, "R8 idle after disable");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule